// File: doc/BRIEF.md
# ARINC 429 Single-Channel Word Receiver

This block takes one ARINC 429 receive channel after the analog front end has split it into two return-to-zero pulse lines: one line pulses for each "1" bit, the other for each "0" bit. Both lines are brought into the system clock domain. The block rebuilds a bit clock from them and shifts each bit into a 32-bit word register. A programmable timer, counting at one eighth of the system rate, finds the quiet interval between words and marks where each word ends.

When a gap closes a word, several conditions decide whether the word is kept. These cover word length, a gap seen earlier, the host lock, odd parity, the channel enable and an optional label match. A kept word goes into a 24-bit data buffer, and in pass-all mode its first 8 bits also go into the label register. A ready flag then tells the host to read the word. The host uses a small byte-read port, and a read sequence, once started, holds off new transfers until it finishes.

Top module: `a429_rx_channel`

## Requirements
- R1: The bit clock is the OR of the two synchronised lines, and the bit value is the "one" line. The first bit received lands in label bit 0, bits 9 to 32 fill data bits 0 to 23 in order, and read index 0 returns data bits 7:0, index 1 bits 15:8, index 2 bits 23:16, and index 3 the label register.
- R2: Each falling edge of the bit clock clears a gap counter. The counter advances once every 8 system clocks and signals a gap when it reaches n, the value in bits 6:0 of the sync register. If n is 0, no gap is ever signalled. An idle time shorter than about 8n clocks does not end a word.
- R3: After reset, the first gap only arms the channel. A word that ends at that first gap is discarded.
- R4: Only a word of exactly 32 bits that ends at a gap can be transferred. A 31-bit or 33-bit burst is dropped.
- R5: When parity_en_i is 1, a word with an even number of ones is discarded. When it is 0, parity is ignored.
- R6: When bit 7 of the sync register is 0, no transfer takes place and ready_o stays low.
- R7: When filter_mode_i is 1, a word transfers only if its first 8 bits equal the label register. The label register is not overwritten by received words in this mode.
- R8: When filter_mode_i is 0, every qualified word loads its first 8 bits into the label register.
- R9: A transfer raises ready_o. A read of index 2 lowers it on the next clock.
- R10: A read of index 0 or 1 sets a lock that a read of index 2 releases. While the lock is set, or on any cycle with a read strobe, no transfer changes the buffer.
- R11: Reset clears ready_o, the label register and the sync register.
- R12: A configuration write with cfg_sel_i = 0 loads the sync register (bit 7 enable, bits 6:0 n). With cfg_sel_i = 1 it loads the label register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_one_i | input | 1 | Asynchronous "one" pulse line |
| line_zero_i | input | 1 | Asynchronous "zero" pulse line |
| parity_en_i | input | 1 | 1 = discard words with even parity |
| filter_mode_i | input | 1 | 1 = label filter, 0 = pass-all |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 = sync register, 1 = label register |
| cfg_data_i | input | 8 | Configuration write data |
| rd_en_i | input | 1 | Read strobe, one clock per byte |
| rd_idx_i | input | 2 | Byte index: 0..2 data, 3 label |
| rd_data_o | output | 8 | Read data for the addressed byte |
| ready_o | output | 1 | A new word is waiting in the buffer |

## Verification
The receiver is driven with words whose bit patterns put distinct values in every byte. This makes a bit-order or byte-lane error visible, and it distinguishes pass-all from label-filter transfers. The same words are also sent in variants that differ in a single property: parity sense, length of 31 or 33 bits, an idle time below the gap threshold, a label mismatch, or the enable bit cleared. Each variant isolates one condition in the transfer decision. A word sent before the first gap shows the arming rule. A word sent in the middle of a host read shows that the lock keeps the earlier bytes intact until the read sequence ends.

// File: rtl/a429_rx_pkg.sv
// Package: shared sizes and the read index encoding of the receive channel.
package a429_rx_pkg;
    localparam int WORD_BITS  = 32;
    localparam int LABEL_BITS = 8;
    localparam int DATA_BITS  = WORD_BITS - LABEL_BITS;
    localparam int BYTE_BITS  = 8;
    localparam int GAP_BITS   = 7;
    localparam int PRESCALE   = 8;
    localparam int CNT_BITS   = 6;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_B0    = 2'd0,
        SEL_B1    = 2'd1,
        SEL_B2    = 2'd2,
        SEL_LABEL = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/a429_line_sync.sv
// Module: a429_line_sync
// Brings the two pulse lines into the clk domain through STAGES flops each,
// builds the bit clock as their OR and reports its rising and falling edges.
// Assumes each pulse and each low interval lasts several clk periods.
module a429_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic one_i,
    input  logic zero_i,
    output logic bit_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             bclk_q;
    logic             bclk;

    assign raw = {one_i, zero_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            // Shift the raw line through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain_q[STAGES-1];
        end
    endgenerate

    assign bclk  = |synced;
    assign bit_o = synced[1];

    // Hold the previous bit clock value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    assign rise_o = bclk & ~bclk_q;
    assign fall_o = ~bclk & bclk_q;

    a_r1_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_o, fall_o}));
endmodule

// File: rtl/a429_gap_timer.sv
// Module: a429_gap_timer
// Measures bit-clock idle time in units of PRESCALE clocks; gap_o pulses once
// when the count reaches limit_i. A limit of zero never produces a gap.
// Assumes fall_i is a one-clock pulse.
module a429_gap_timer #(
    parameter int N_W      = 7,
    parameter int PRESCALE = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fall_i,
    input  logic [N_W-1:0] limit_i,
    output logic           gap_o
);
    localparam int PRE_W = $clog2(PRESCALE);

    logic [PRE_W-1:0] pre_q;
    logic [N_W-1:0]   cnt_q;
    logic             tick;

    assign tick = (pre_q == PRE_W'(PRESCALE - 1));

    // Free-running prescaler that produces one tick every PRESCALE clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Idle counter: cleared by a falling bit-clock edge, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (fall_i)                  cnt_q <= '0;
        else if (tick && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
    end

    assign gap_o = tick && !fall_i && (limit_i != '0) &&
                   (cnt_q == limit_i - 1'b1);

    a_r2_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> (cnt_q == '0));
    a_r2_gap_reaches_n: assert property (@(posedge clk) disable iff (!rst_n)
        gap_o |=> (cnt_q == $past(limit_i)));
endmodule

// File: rtl/a429_word_shift.sv
// Module: a429_word_shift
// Shifts received bits in from the top so the first bit ends at bit 0, and
// counts bits with saturation. A gap (clear_i) restarts the count.
module a429_word_shift #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             bit_i,
    input  logic             clear_i,
    output logic [WIDTH-1:0] word_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Shift register loaded on each rising bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_o <= '0;
        else if (rise_i) word_o <= {bit_i, word_o[WIDTH-1:1]};
    end

    // Bit counter: restarts at a gap, saturates at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                          count_o <= '0;
        else if (clear_i)                    count_o <= rise_i ? CNT_W'(1) : '0;
        else if (rise_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end

    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !clear_i && count_o != CNT_MAX) |=>
        (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/a429_rx_channel.sv
// Module: a429_rx_channel
// One ARINC 429 receive channel: line synchroniser, gap timer and shifter,
// then the transfer decision, the label/sync/data registers and the host
// byte-read port with its read lock. Assumes rd_en_i lasts one clock per byte.
module a429_rx_channel
    import a429_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_one_i,
    input  logic                 line_zero_i,
    input  logic                 parity_en_i,
    input  logic                 filter_mode_i,
    input  logic                 cfg_wr_i,
    input  logic                 cfg_sel_i,
    input  logic [BYTE_BITS-1:0] cfg_data_i,
    input  logic                 rd_en_i,
    input  logic [1:0]           rd_idx_i,
    output logic [BYTE_BITS-1:0] rd_data_o,
    output logic                 ready_o
);
    localparam int ENA_BIT = BYTE_BITS - 1;

    logic                  bit_s, rise_s, fall_s, gap_s;
    logic [WORD_BITS-1:0]  word_s;
    logic [CNT_BITS-1:0]   cnt_s;
    logic [BYTE_BITS-1:0]  sync_q, label_q;
    logic [DATA_BITS-1:0]  buf_q;
    logic                  ready_q, lock_q, armed_q;
    logic                  parity_ok, label_ok, xfer;
    logic                  rd_last, rd_first;

    a429_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .one_i(line_one_i), .zero_i(line_zero_i),
        .bit_o(bit_s), .rise_o(rise_s), .fall_o(fall_s));

    a429_gap_timer #(.N_W(GAP_BITS), .PRESCALE(PRESCALE)) u_gap (
        .clk(clk), .rst_n(rst_n), .fall_i(fall_s),
        .limit_i(sync_q[GAP_BITS-1:0]), .gap_o(gap_s));

    a429_word_shift #(.WIDTH(WORD_BITS), .CNT_W(CNT_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .rise_i(rise_s), .bit_i(bit_s),
        .clear_i(gap_s), .word_o(word_s), .count_o(cnt_s));

    assign rd_last  = rd_en_i && (rd_idx_i == SEL_B2);
    assign rd_first = rd_en_i && (rd_idx_i == SEL_B0 || rd_idx_i == SEL_B1);

    assign parity_ok = !parity_en_i || (^word_s);
    assign label_ok  = !filter_mode_i || (word_s[LABEL_BITS-1:0] == label_q);
    assign xfer = gap_s && armed_q && (cnt_s == CNT_BITS'(WORD_BITS)) &&
                  !lock_q && !rd_en_i && sync_q[ENA_BIT] && parity_ok && label_ok;

    // The first gap after reset only arms the channel.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed_q <= 1'b0;
        else if (gap_s) armed_q <= 1'b1;
    end

    // Sync/enable register, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sync_q <= '0;
        else if (cfg_wr_i && !cfg_sel_i) sync_q <= cfg_data_i;
    end

    // Label register: host write, or received label in pass-all mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                        label_q <= '0;
        else if (cfg_wr_i && cfg_sel_i)    label_q <= cfg_data_i;
        else if (xfer && !filter_mode_i)   label_q <= word_s[LABEL_BITS-1:0];
    end

    // Data buffer takes the 24 non-label bits of a qualified word.
    always_ff @(posedge clk) begin
        if (!rst_n)    buf_q <= '0;
        else if (xfer) buf_q <= word_s[WORD_BITS-1:LABEL_BITS];
    end

    // Ready flag: set by a transfer, cleared by reading the last data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       ready_q <= 1'b0;
        else if (xfer)    ready_q <= 1'b1;
        else if (rd_last) ready_q <= 1'b0;
    end

    // Read lock: held from the first byte read until the last byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_q <= 1'b0;
        else if (rd_last)  lock_q <= 1'b0;
        else if (rd_first) lock_q <= 1'b1;
    end

    // Byte read multiplexer.
    always_comb begin
        unique case (rd_sel_e'(rd_idx_i))
            SEL_B0:    rd_data_o = buf_q[BYTE_BITS-1:0];
            SEL_B1:    rd_data_o = buf_q[2*BYTE_BITS-1:BYTE_BITS];
            SEL_B2:    rd_data_o = buf_q[3*BYTE_BITS-1:2*BYTE_BITS];
            default:   rd_data_o = label_q;
        endcase
    end

    assign ready_o = ready_q;

    a_r3_unarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !ready_q);
    a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_q[ENA_BIT] |=> $stable(buf_q));
    a_r7_filter_label_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_mode_i && !(cfg_wr_i && cfg_sel_i)) |=> $stable(label_q));
    a_r9_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> !ready_q);
    a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q || rd_en_i) |=> $stable(buf_q));
endmodule

// File: tb/sim_a429_rx_channel.sv
// Scoreboard bench: the driver pushes expected words, the monitor reads them back.
module sim_a429_rx_channel;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF_BIT   = 4;
    localparam int  IDLE       = 60;
    localparam int  WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       one = 1'b0, zero = 1'b0;
    logic       par_en = 1'b0, filt = 1'b0;
    logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       ready;

    int checks = 0;
    int errors = 0;
    logic [31:0] expq[$];
    logic mon_on = 1'b0;
    logic mon_busy = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    a429_rx_channel u0 (
        .clk(clk), .rst_n(rst_n), .line_one_i(one), .line_zero_i(zero),
        .parity_en_i(par_en), .filter_mode_i(filt), .cfg_wr_i(cfg_wr),
        .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .rd_en_i(rd_en),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data), .ready_o(ready));

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic sel, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_data = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_idx = idx;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    // R1: bit i of w is sent i-th; the "one" line pulses for 1, "zero" for 0.
    task automatic send_bits(input logic [39:0] w, input int n, input int idle);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (w[i]) one = 1'b1; else zero = 1'b1;
            repeat (HALF_BIT) @(negedge clk);
            one = 1'b0; zero = 1'b0;
            repeat (HALF_BIT - 1) @(negedge clk);
        end
        repeat (idle) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w, input logic expect_it);
        if (expect_it) expq.push_back(w);
        send_bits({8'h00, w}, 32, IDLE);
    endtask

    function automatic logic [31:0] odd(input logic [31:0] w);
        return (^w) ? w : (w ^ 32'h8000_0000);
    endfunction

    task automatic drain(input string req);
        int t = 0;
        while ((expq.size() != 0 || mon_busy) && t < 500) begin
            @(posedge clk); t++;
        end
        check(expq.size(), 0, req);
    endtask

    // Monitor: on ready, pop the expected word and compare all four bytes.
    initial begin
        logic [31:0] e;
        logic [7:0] d;
        forever begin
            @(negedge clk);
            if (mon_on && ready) begin
                mon_busy = 1'b1;
                if (expq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected ready actual=1 expected=0");
                    rd(2'd2, d);
                end else begin
                    e = expq.pop_front();
                    rd(2'd0, d); check(d, e[15:8],  "R1 byte0");
                    rd(2'd1, d); check(d, e[23:16], "R1 byte1");
                    rd(2'd2, d); check(d, e[31:24], "R1 byte2");
                    rd(2'd3, d); check(d, e[7:0],   "R8 label");
                    @(negedge clk);
                    check(ready, 1'b0, "R9 ready cleared");
                end
                mon_busy = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [31:0] wa, wc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        check(ready, 1'b0, "R11 ready after reset");
        rd(2'd3, d); check(d, 8'h00, "R11 label after reset");

        // R3: a word finishing at the first gap is dropped.
        mon_on = 1'b1;
        cfg(1'b0, 8'h84);  // R12: enable, n = 4
        send_word(32'hC3A5_9612, 1'b0);
        check(ready, 1'b0, "R3 first gap ignored");
        send_word(32'h1234_5678, 1'b1);
        drain("R1 pass-all word");
        send_word(32'hFEDC_BA98, 1'b1);
        drain("R8 second pass-all word");

        // R4: wrong lengths.
        send_bits(40'h00_8765_4321, 31, IDLE);
        check(ready, 1'b0, "R4 31-bit burst dropped");
        send_bits(40'h01_8765_4321, 33, IDLE);
        check(ready, 1'b0, "R4 33-bit burst dropped");
        send_word(32'h0F0F_3C3C, 1'b1);
        drain("R4 32-bit accepted");

        // R5: parity.
        par_en = 1'b1;
        send_word(odd(32'h2468_ACE0), 1'b1);
        drain("R5 odd accepted");
        send_word(odd(32'h2468_ACE0) ^ 32'h0000_0100, 1'b0);
        check(ready, 1'b0, "R5 even dropped");
        par_en = 1'b0;
        send_word(32'h0000_0003, 1'b1);
        drain("R5 even accepted when off");

        // R6: channel disabled; label register kept.
        cfg(1'b0, 8'h04);
        send_word(32'h5555_AAAA, 1'b0);
        check(ready, 1'b0, "R6 disabled no ready");
        rd(2'd3, d); check(d, 8'h03, "R6 label unchanged");
        cfg(1'b0, 8'h84);

        // R7: label filter.
        filt = 1'b1;
        cfg(1'b1, 8'h5A);
        send_word(32'h1122_335A, 1'b1);
        drain("R7 matching label");
        send_word(32'h4455_6633, 1'b0);
        check(ready, 1'b0, "R7 mismatch dropped");
        rd(2'd3, d); check(d, 8'h5A, "R7 label kept");
        filt = 1'b0;

        // R2: idle shorter than the gap joins words; none transfer.
        cfg(1'b0, 8'h94);  // n = 20
        repeat (200) @(negedge clk);
        send_bits({8'h00, 32'h7777_1111}, 32, IDLE);
        send_bits({8'h00, 32'h7777_2222}, 32, IDLE);
        repeat (200) @(negedge clk);
        check(ready, 1'b0, "R2 short idle is not a gap");
        cfg(1'b0, 8'h84);
        repeat (60) @(negedge clk);
        send_word(32'hA1B2_C3D4, 1'b1);
        drain("R2 gap restored");

        // R10: lock during a read sequence.
        mon_on = 1'b0;
        wa = 32'h3344_5566;
        wc = 32'h9988_7766;
        send_bits({8'h00, wa}, 32, IDLE);
        check(ready, 1'b1, "R9 ready raised");
        rd(2'd0, d); check(d, wa[15:8], "R10 byte0");
        send_bits({8'h00, 32'hDEAD_BEEF}, 32, IDLE);
        rd(2'd1, d); check(d, wa[23:16], "R10 byte1 kept under lock");
        rd(2'd2, d); check(d, wa[31:24], "R10 byte2 kept under lock");
        @(negedge clk);
        check(ready, 1'b0, "R9 cleared by last byte");
        send_bits({8'h00, wc}, 32, IDLE);
        check(ready, 1'b1, "R10 lock released");
        rd(2'd0, d); check(d, wc[15:8], "R10 new byte0");
        rd(2'd1, d); check(d, wc[23:16], "R10 new byte1");
        rd(2'd2, d); check(d, wc[31:24], "R10 new byte2");
        mon_on = 1'b1;

        repeat (20) @(negedge clk);
        check(ready, 1'b0, "R9 idle at end");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule